// File: doc/BRIEF.md
# Dual-Mode Message Queue Index and Status Tracker

This block tracks the slot indexes of a message queue whose depth is set at run time, and reports the queue's condition through one 16-bit status word. A mode input picks one of two roles. As a transmit queue, software pushes messages in and the bus engine removes them by reporting a completion. As a receive buffer, the bus engine pushes incoming messages and software pops them. Message payloads are held elsewhere. Only indexes, occupancy and status are modelled here.

The occupancy is held by a small fill state machine with three states. `FILL_EMPTY` means no message is held. `FILL_PART` means at least one message is held and at least one slot is free. `FILL_FULL` means every slot is taken. Its transitions are: `FILL_EMPTY -> FILL_PART` on an accepted push when the depth is greater than one; `FILL_EMPTY -> FILL_FULL` on an accepted push when the depth is one; `FILL_PART -> FILL_FULL` on a push alone when one slot was left free; `FILL_PART -> FILL_EMPTY` on a removal alone when one message was held; `FILL_FULL -> FILL_PART` on a removal when the depth is greater than one; `FILL_FULL -> FILL_EMPTY` on a removal when the depth is one. Any state returns to `FILL_EMPTY` on a queue clear.

Transmit outcome bits, a transmit-attempts-exhausted flag and a receive overflow flag sit beside the indexes. Some of them clear when the status word is read. Others change only when a message finishes. The two sticky flags are cleared by writing zero to them.

Top module: `msgq_status`

## Requirements
- R1: The depth is `cfg_size + 1`. The head and tail indexes step from depth-1 back to 0. The occupancy never exceeds the depth.
- R2: Status bits 15:13 always read 0. Bits 12:8 hold the head index in transmit mode (`tx_mode`=1) and the tail index in receive mode (`tx_mode`=0).
- R3: In receive mode, a push into a full queue is dropped. The tail and occupancy stay the same and the overflow flag (bit 3) is set. In transmit mode, a push into a full queue is ignored and sets no flag.
- R4: A removal from an empty queue is ignored. In transmit mode `pop` has no effect. In receive mode the completion events have no effect.
- R5: In transmit mode, `ev_done` or `ev_abort` on a non-empty queue retires the head message. At that moment bit 7 (aborted) takes `ev_abort`, bit 6 (lost arbitration) takes `ev_lost_arb` and bit 5 (bus error) takes `ev_bus_err`. Bits 6 and 5 change at no other time except a queue clear.
- R6: A status read clears bit 7 after the word has been captured. A completion in the same cycle as the read takes priority.
- R7: `ev_attempts_out` in transmit mode sets bit 4. Bit 4 reads 0 in receive mode, and the flag is kept underneath.
- R8: Bit 3 reads 0 in transmit mode, and the flag is kept underneath.
- R9: A register write with a 0 in bit 4 or bit 3 clears that flag. A 1 has no effect. A set in the same cycle as a clearing write wins.
- R10: The fill flags are computed from occupancy `n` and depth `d`. In transmit mode, bit 0 is `n != d`, bit 1 is `2n <= d` and bit 2 is `n == 0`. In receive mode, bit 0 is `n != 0`, bit 1 is `2n >= d` and bit 2 is `n == d`.
- R11: `fifo_clr` returns both indexes and the occupancy to 0 and clears bits 7:3.
- R12: `reg_rd` captures the current status word into `reg_rdata` at the next clock edge. Otherwise `reg_rdata` holds its value, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous queue clear |
| tx_mode | input | 1 | 1 = transmit queue, 0 = receive buffer |
| cfg_size | input | 5 | Depth minus one; change only together with `fifo_clr` |
| push | input | 1 | Add one message at the tail |
| pop | input | 1 | Remove the head message (receive mode) |
| ev_done | input | 1 | Head message sent successfully (transmit mode) |
| ev_abort | input | 1 | Head message aborted (transmit mode) |
| ev_lost_arb | input | 1 | Qualifier: the finishing message lost arbitration |
| ev_bus_err | input | 1 | Qualifier: the finishing message saw a bus error |
| ev_attempts_out | input | 1 | Transmit attempts exhausted |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 16 | Status write data |
| reg_rdata | output | 16 | Captured status word |

## Verification
The bench targets index wrap at several depths, including a depth of one. A design that got this wrong would report an index past depth-1 or a fill level that never reaches full. It drives a push into a full receive buffer and a full transmit queue. A faulty design would advance the tail, or raise overflow in the wrong mode. It reads the status in the same cycle as an abort, where a wrong priority loses the aborted bit. It also clears a sticky flag in the same cycle its set event fires, where a wrong priority drops an interrupt. Both half-level boundaries are checked at an even depth, and the mode masks are checked while the hidden flag is still set. This catches designs that compare with the wrong inequality or that clear a flag instead of masking it.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

    localparam int STAT_W     = 16;
    localparam int STAT_IDX_W = 5;

    localparam int B_ABORT  = 7;
    localparam int B_LARB   = 6;
    localparam int B_BERR   = 5;
    localparam int B_ATIF   = 4;
    localparam int B_OVF    = 3;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic aborted;
        logic lost_arb;
        logic bus_err;
    } tx_outcome_t;

endpackage

// File: rtl/msgq_ptrs.sv
module msgq_ptrs
    import msgq_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [IDX_W-1:0] cfg_size,
    input  logic             enq_req,
    input  logic             deq_req,
    output logic             enq_drop,
    output logic             deq_ok,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] depth
);

    fill_state_e      state_q, state_d;
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] occ_q, occ_d;
    logic             enq_ok;
    logic             is_full, is_empty;
    logic             one_left, one_held, depth_one;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p,
                                                  input logic [IDX_W-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

    assign depth     = {1'b0, cfg_size} + CNT_W'(1);
    assign depth_one = (cfg_size == '0);
    assign one_left  = (occ_q == depth - CNT_W'(1));
    assign one_held  = (occ_q == CNT_W'(1));

    // Output decode of the fill state
    always_comb begin
        is_full  = 1'b0;
        is_empty = 1'b0;
        unique case (state_q)
            FILL_EMPTY: is_empty = 1'b1;
            FILL_PART:  ;
            FILL_FULL:  is_full  = 1'b1;
            default:    is_empty = 1'b1;
        endcase
    end

    assign enq_ok   = enq_req && !is_full;
    assign deq_ok   = deq_req && !is_empty;
    assign enq_drop = enq_req && is_full;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (enq_ok)
                    state_d = depth_one ? FILL_FULL : FILL_PART;
            end
            FILL_PART: begin
                if (enq_ok && !deq_ok && one_left)
                    state_d = FILL_FULL;
                else if (deq_ok && !enq_ok && one_held)
                    state_d = FILL_EMPTY;
            end
            FILL_FULL: begin
                if (deq_ok)
                    state_d = depth_one ? FILL_EMPTY : FILL_PART;
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    always_comb begin
        occ_d = occ_q;
        if (enq_ok && !deq_ok)
            occ_d = occ_q + CNT_W'(1);
        else if (deq_ok && !enq_ok)
            occ_d = occ_q - CNT_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
            occ_q   <= '0;
        end else if (clr) begin
            state_q <= FILL_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
            occ_q   <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
            if (enq_ok)
                tail_q <= step_idx(tail_q, cfg_size);
            if (deq_ok)
                head_q <= step_idx(head_q, cfg_size);
        end
    end

    assign head = head_q;
    assign tail = tail_q;
    assign occ  = occ_q;

endmodule

// File: rtl/msgq_flags.sv
module msgq_flags
    import msgq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        tx_mode,
    input  logic        cmpl_ok,
    input  logic        ev_abort,
    input  logic        ev_lost_arb,
    input  logic        ev_bus_err,
    input  logic        ev_attempts_out,
    input  logic        rx_drop,
    input  logic        rd_strobe,
    input  logic        atif_wclr,
    input  logic        ovf_wclr,
    output tx_outcome_t outcome,
    output logic        atif,
    output logic        ovf
);

    tx_outcome_t outcome_q;
    logic        atif_q, ovf_q;
    logic        atif_set, ovf_set;

    assign atif_set = tx_mode && ev_attempts_out;
    assign ovf_set  = !tx_mode && rx_drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outcome_q <= '0;
            atif_q    <= 1'b0;
            ovf_q     <= 1'b0;
        end else if (clr) begin
            outcome_q <= '0;
            atif_q    <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (cmpl_ok) begin
                outcome_q.aborted  <= ev_abort;
                outcome_q.lost_arb <= ev_lost_arb;
                outcome_q.bus_err  <= ev_bus_err;
            end else if (rd_strobe) begin
                outcome_q.aborted  <= 1'b0;
            end

            if (atif_set)
                atif_q <= 1'b1;
            else if (atif_wclr)
                atif_q <= 1'b0;

            if (ovf_set)
                ovf_q <= 1'b1;
            else if (ovf_wclr)
                ovf_q <= 1'b0;
        end
    end

    assign outcome = outcome_q;
    assign atif    = atif_q;
    assign ovf     = ovf_q;

endmodule

// File: rtl/msgq_regif.sv
module msgq_regif
    import msgq_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic [IDX_W-1:0]  head,
    input  logic [IDX_W-1:0]  tail,
    input  logic [CNT_W-1:0]  occ,
    input  logic [CNT_W-1:0]  depth,
    input  tx_outcome_t       outcome,
    input  logic              atif,
    input  logic              ovf,
    input  logic              rd_strobe,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [STAT_W-1:0] rdata
);

    localparam int CMP_W = CNT_W + 1;

    logic [CMP_W-1:0]  occ2, depth_x;
    logic [2:0]        fill;
    logic [STAT_W-1:0] word;
    logic [STAT_W-1:0] rdata_q;

    assign occ2    = {occ, 1'b0};
    assign depth_x = {1'b0, depth};
    assign cur_idx = tx_mode ? head : tail;

    always_comb begin
        if (tx_mode) begin
            fill[0] = (occ != depth);
            fill[1] = (occ2 <= depth_x);
            fill[2] = (occ == '0);
        end else begin
            fill[0] = (occ != '0);
            fill[1] = (occ2 >= depth_x);
            fill[2] = (occ == depth);
        end
    end

    always_comb begin
        word                 = '0;
        word[12:8]           = STAT_IDX_W'(cur_idx);
        word[B_ABORT]        = outcome.aborted;
        word[B_LARB]         = outcome.lost_arb;
        word[B_BERR]         = outcome.bus_err;
        word[B_ATIF]         = atif && tx_mode;
        word[B_OVF]          = ovf && !tx_mode;
        word[2:0]            = fill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_strobe)
            rdata_q <= word;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/msgq_status.sv
module msgq_status
    import msgq_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_clr,
    input  logic             tx_mode,
    input  logic [IDX_W-1:0] cfg_size,
    input  logic             push,
    input  logic             pop,
    input  logic             ev_done,
    input  logic             ev_abort,
    input  logic             ev_lost_arb,
    input  logic             ev_bus_err,
    input  logic             ev_attempts_out,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata
);

    localparam int CNT_W = IDX_W + 1;

    logic             deq_req, deq_ok, enq_drop, cmpl_ok;
    logic [IDX_W-1:0] head, tail, cur_idx;
    logic [CNT_W-1:0] occ, depth;
    tx_outcome_t      outcome;
    logic             atif_q, ovf_q, aborted_q;
    logic             atif_wclr, ovf_wclr;

    assign deq_req   = tx_mode ? (ev_done || ev_abort) : pop;
    assign cmpl_ok   = tx_mode && deq_ok;
    assign atif_wclr = reg_wr && !reg_wdata[B_ATIF];
    assign ovf_wclr  = reg_wr && !reg_wdata[B_OVF];
    assign aborted_q = outcome.aborted;

    msgq_ptrs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .cfg_size (cfg_size),
        .enq_req  (push),
        .deq_req  (deq_req),
        .enq_drop (enq_drop),
        .deq_ok   (deq_ok),
        .head     (head),
        .tail     (tail),
        .occ      (occ),
        .depth    (depth)
    );

    msgq_flags u_flags (
        .clk             (clk),
        .rst_n           (rst_n),
        .clr             (fifo_clr),
        .tx_mode         (tx_mode),
        .cmpl_ok         (cmpl_ok),
        .ev_abort        (ev_abort),
        .ev_lost_arb     (ev_lost_arb),
        .ev_bus_err      (ev_bus_err),
        .ev_attempts_out (ev_attempts_out),
        .rx_drop         (enq_drop),
        .rd_strobe       (reg_rd),
        .atif_wclr       (atif_wclr),
        .ovf_wclr        (ovf_wclr),
        .outcome         (outcome),
        .atif            (atif_q),
        .ovf             (ovf_q)
    );

    msgq_regif #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_mode   (tx_mode),
        .head      (head),
        .tail      (tail),
        .occ       (occ),
        .depth     (depth),
        .outcome   (outcome),
        .atif      (atif_q),
        .ovf       (ovf_q),
        .rd_strobe (reg_rd),
        .cur_idx   (cur_idx),
        .rdata     (reg_rdata)
    );

endmodule

// File: rtl/msgq_status_chk.sv
module msgq_status_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_clr,
    input logic             tx_mode,
    input logic [IDX_W-1:0] cfg_size,
    input logic             push,
    input logic             pop,
    input logic             ev_attempts_out,
    input logic             reg_rd,
    input logic [15:0]      reg_rdata,
    input logic [IDX_W:0]   occ,
    input logic [IDX_W-1:0] cur_idx,
    input logic             cmpl_ok,
    input logic             aborted_q,
    input logic             atif_q,
    input logic             ovf_q
);

    logic [IDX_W:0] dep;
    assign dep = {1'b0, cfg_size} + (IDX_W+1)'(1);

    assert_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15:13] == 3'b000);

    assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_clr |-> (cur_idx <= cfg_size && occ <= dep));

    assert_rx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_mode && push && !pop && !fifo_clr && occ == dep)
        |=> (ovf_q && occ == $past(occ)));

    assert_rd_clears_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !cmpl_ok && !fifo_clr) |=> !aborted_q);

    assert_atif_rx_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !tx_mode) |=> !reg_rdata[4]);

    assert_ovf_tx_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && tx_mode) |=> !reg_rdata[3]);

    assert_atif_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && ev_attempts_out && !fifo_clr) |=> atif_q);

    assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (occ == '0 && cur_idx == '0 && !aborted_q && !atif_q && !ovf_q));

endmodule

bind msgq_status msgq_status_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/msgq_status_tb.sv
module msgq_status_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        tx_mode = 1'b1;
    logic [4:0]  cfg_size = 5'd3;
    logic        push = 1'b0, pop = 1'b0;
    logic        ev_done = 1'b0, ev_abort = 1'b0;
    logic        ev_lost_arb = 1'b0, ev_bus_err = 1'b0, ev_attempts_out = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    msgq_status u_dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic idle();
        push = 0; pop = 0; ev_done = 0; ev_abort = 0; ev_lost_arb = 0;
        ev_bus_err = 0; ev_attempts_out = 0; reg_rd = 0; reg_wr = 0;
        fifo_clr = 0; reg_wdata = '0;
    endtask

    task automatic do_push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); push = 1;
            @(negedge clk); idle();
        end
    endtask

    task automatic do_pop();
        @(negedge clk); pop = 1;
        @(negedge clk); idle();
    endtask

    task automatic do_evt(input logic d, input logic a, input logic la, input logic be, input logic ato);
        @(negedge clk);
        ev_done = d; ev_abort = a; ev_lost_arb = la; ev_bus_err = be; ev_attempts_out = ato;
        @(negedge clk); idle();
    endtask

    task automatic do_write(input logic [15:0] v, input logic ato);
        @(negedge clk); reg_wr = 1; reg_wdata = v; ev_attempts_out = ato;
        @(negedge clk); idle();
    endtask

    task automatic rd_check(input string req, input logic [15:0] exp);
        @(negedge clk); reg_rd = 1;
        @(negedge clk); idle();
        check(req, reg_rdata, exp);
    endtask

    task automatic clr_fifo(input logic [4:0] size);
        @(negedge clk); fifo_clr = 1; cfg_size = size;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        check("R12 rdata after reset", reg_rdata, 16'h0000);
        rd_check("R10 tx empty after reset", 16'h0007);
    endtask

    task automatic t_tx_outcomes();
        clr_fifo(5'd3); tx_mode = 1;
        do_push(3);
        rd_check("R10 tx occ3 of 4", 16'h0001);
        do_evt(1, 0, 0, 0, 0);
        do_evt(0, 1, 1, 1, 0);
        rd_check("R5 abort with lost arb and bus error", 16'h02E3);
        rd_check("R6 read clears aborted", 16'h0263);
        do_evt(0, 0, 1, 1, 0);
        do_evt(0, 0, 0, 0, 0);
        @(negedge clk); ev_lost_arb = 0; ev_bus_err = 0; @(negedge clk); idle();
        rd_check("R5 qualifiers alone do nothing", 16'h0263);
        do_evt(1, 0, 0, 0, 0);
        rd_check("R5 success clears outcome", 16'h0307);
        do_evt(1, 0, 0, 0, 0);
        rd_check("R4 completion on empty ignored", 16'h0307);
        do_pop();
        rd_check("R4 pop ignored in tx mode", 16'h0307);
        do_push(1);
        @(negedge clk); ev_abort = 1; reg_rd = 1;
        @(negedge clk); idle();
        check("R12 read captures pre-abort word", reg_rdata, 16'h0303);
        rd_check("R6 abort wins over read, R1 head wraps", 16'h0087);
        rd_check("R6 aborted cleared by later read", 16'h0007);
    endtask

    task automatic t_tx_interrupt();
        do_evt(0, 0, 0, 0, 1);
        rd_check("R7 attempts-exhausted set", 16'h0017);
        do_write(16'h0010, 0);
        rd_check("R9 write 1 no effect", 16'h0017);
        do_write(16'h0000, 1);
        rd_check("R9 set wins over clear", 16'h0017);
        do_write(16'h0000, 0);
        rd_check("R9 write 0 clears", 16'h0007);
        do_evt(0, 0, 0, 0, 1);
        tx_mode = 0;
        rd_check("R7 masked in rx mode", 16'h0000);
        tx_mode = 1;
        rd_check("R7 flag kept under mask", 16'h0017);
        do_write(16'h0000, 0);
        do_push(4);
        rd_check("R10 tx full", 16'h0000);
        do_push(1);
        rd_check("R3 tx push into full ignored", 16'h0000);
        tx_mode = 0;
        rd_check("R3 tx drop sets no overflow", 16'h0007);
        tx_mode = 1;
    endtask

    task automatic t_clear();
        do_evt(0, 1, 1, 0, 1);
        clr_fifo(5'd3);
        rd_check("R11 clear resets all", 16'h0007);
    endtask

    task automatic t_rx();
        clr_fifo(5'd3); tx_mode = 0;
        do_pop();
        rd_check("R4 rx pop on empty ignored", 16'h0000);
        do_push(1);
        rd_check("R2 rx index is tail", 16'h0101);
        do_push(3);
        rd_check("R1 tail wraps, R10 rx full", 16'h0007);
        do_push(1);
        rd_check("R3 rx overflow drop", 16'h000F);
        do_pop();
        rd_check("R10 rx occ3", 16'h000B);
        tx_mode = 1;
        rd_check("R8 overflow masked in tx, R2 head index", 16'h0101);
        tx_mode = 0;
        do_write(16'h0008, 0);
        rd_check("R9 write 1 keeps overflow", 16'h000B);
        do_evt(1, 1, 1, 1, 1);
        rd_check("R4 events ignored in rx", 16'h000B);
        do_write(16'h0000, 0);
        rd_check("R9 write 0 clears overflow", 16'h0003);
    endtask

    task automatic t_half();
        clr_fifo(5'd5); tx_mode = 1;
        do_push(3);
        rd_check("R10 tx half-empty at 3 of 6", 16'h0003);
        do_push(1);
        rd_check("R10 tx not half-empty at 4 of 6", 16'h0001);
        tx_mode = 0;
        rd_check("R10 rx half-full at 4 of 6", 16'h0403);
        do_pop();
        rd_check("R10 rx half-full at 3 of 6", 16'h0403);
        do_pop();
        rd_check("R10 rx not half-full at 2 of 6", 16'h0401);
        clr_fifo(5'd0);
        do_push(1);
        rd_check("R1 depth one full", 16'h0007);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_outcomes();
        t_tx_interrupt();
        t_clear();
        t_rx();
        t_half();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule